// File: doc/BRIEF.md
# External Interrupt Request Sequencer

This block decides when a small 8-bit CPU core has to take an external interrupt, and it carries out the entry sequence for that interrupt. The interrupt line is active low. It passes through a synchronizer. A falling edge on it sets a pending latch. The pending latch and the live low level of the line together form the request. The core sends a strobe at each instruction boundary. At such a boundary, if the request is active and the mask bit in the core's condition code snapshot is clear, the block takes the interrupt.

Entry runs in a fixed order. First, five bytes of machine state go to a downward-growing stack, one byte per cycle, through a byte-wide write port. Next, the block pulses a request to set the interrupt mask. It then reads the two-byte service vector and loads the program counter with it, and hands back the updated stack pointer. The core stalls while the block is busy.

The core's return-from-interrupt strobe marks the end of service. If the line is still held low when the mask has been restored to clear, the level term alone re-enters the interrupt. This is how several open-drain sources can share one line. The block also measures the spacing between falling edges. It flags a pulse that arrives while an interrupt is still in service.

Top module: `irq_sequencer`

## Requirements
- R1: An interrupt is taken only in a cycle where `insn_boundary` is 1, the request is active (a pending edge or the synchronized line low), and bit 3 of `ccr_in` (the mask) is 0. Without a boundary strobe, no entry starts.
- R2: Entry writes five bytes on consecutive cycles. The first write comes in the cycle after the accepting edge. The bytes, in order, are the PC low byte, the PC high byte, the X snapshot, the A snapshot and the CCR snapshot. They go to addresses `sp_in`, `sp_in`-1, `sp_in`-2, `sp_in`-3 and `sp_in`-4.
- R3: `imask_set` pulses for exactly one cycle, in the cycle right after the last write. The pushed CCR byte is the value from before entry.
- R4: The block reads the vector high byte at 0x1FFA and then the low byte at 0x1FFB. The read port has one cycle of latency. Two cycles after the first read, `pc_load` is 1, `pc_value` holds {high, low}, `sp_load` is 1 and `sp_value` equals `sp_in`-5.
- R5: `busy` is 1 from the first write through the `pc_load` cycle, and 0 in every other cycle.
- R6: A falling edge that arrives while the mask is set stays pending after the line returns high. It is taken once the mask clears.
- R7: Starting an entry clears the pending latch. A single pulse is therefore serviced once only, and no second entry follows the return.
- R8: If the line is held low through a return and the mask is cleared again, a new entry follows without any new edge.
- R9: Reset clears a pending latch. A pulse seen before reset gives no entry after it.
- R10: `pulse_violation` is set if a new falling edge arrives after an entry has started and before `rti_strobe`. Once set, it stays set until reset. An edge after the return, or a line held low, does not set it.
- R11: `pulse_gap` captures, at each synchronized falling edge, the number of cycles since the previous one. The count saturates at all ones.
- R12: After reset, `busy`, `mem_we`, `mem_re`, `pc_load`, `imask_set`, `sp_load` and `pulse_violation` are 0, and `pulse_gap` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| irq_n | input | 1 | External interrupt line, active low, asynchronous |
| insn_boundary | input | 1 | Instruction-boundary strobe from the core |
| rti_strobe | input | 1 | One-cycle pulse when the core completes a return from interrupt |
| pc_in | input | 16 | Program counter snapshot |
| x_in | input | 8 | Index register snapshot |
| a_in | input | 8 | Accumulator snapshot |
| ccr_in | input | 8 | Condition code snapshot, bit 3 is the interrupt mask |
| sp_in | input | ADDR_W | Stack pointer snapshot |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_re` |
| mem_we | output | 1 | Stack byte write enable |
| mem_re | output | 1 | Vector byte read enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Stack byte write data |
| busy | output | 1 | Entry in progress, core must stall |
| imask_set | output | 1 | One-cycle request to set the CCR mask |
| pc_load | output | 1 | One-cycle program counter load strobe |
| pc_value | output | 16 | Service routine address |
| sp_load | output | 1 | One-cycle stack pointer load strobe |
| sp_value | output | ADDR_W | Stack pointer after the pushes |
| pulse_violation | output | 1 | Sticky flag for an edge that arrives during service |
| pulse_gap | output | CNT_W | Cycles between the last two falling edges |

## Verification
The bench keeps the defaults for the 13-bit address, the 0x1FFA vector, mask bit 3 and the two-stage synchronizer, so the push addresses and vector reads it checks are the real ones. It builds the block with `CNT_W` = 6, so the spacing counter saturates at 63. An idle wait of about a hundred cycles is then enough to test saturation, alongside an exact 10-cycle spacing. A bench-side core model sets the mask on `imask_set`, and the bench restores the mask at each return. This lets the bench test masked pulses, held-low re-entry and pulses that arrive during service.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PUSH,
    SQ_VEC_HI,
    SQ_VEC_LO,
    SQ_LOAD
  } seq_state_e;

  localparam int unsigned STACK_BYTES = 5;
  localparam int unsigned IDX_W = 3;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_n,
  input  logic clear,
  output logic line_low,
  output logic fall,
  output logic pending
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pend_q, pend_d;

  // synchronizer chain, idle level is high
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= irq_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[MSB-1:0], irq_n};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[MSB];
  end

  assign line_low = ~sync_q[MSB];
  assign fall     = prev_q & ~sync_q[MSB];

  // servicing clears the latch and takes priority over a new edge
  always_comb begin
    pend_d = pend_q;
    if (clear)     pend_d = 1'b0;
    else if (fall) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pending = pend_q;

  AST_LATCH_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !pending); // R7
  AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !clear) |=> pending); // R6
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 13,
  parameter int unsigned          MASK_BIT = 3,
  parameter logic [ADDR_W-1:0]    VEC_ADDR = 13'h1FFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_boundary,
  input  logic              request,
  input  logic [15:0]       pc_in,
  input  logic [7:0]        x_in,
  input  logic [7:0]        a_in,
  input  logic [7:0]        ccr_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [7:0]        mem_rdata,
  output logic              start,
  output logic              busy,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              imask_set,
  output logic              pc_load,
  output logic [15:0]       pc_value,
  output logic              sp_load,
  output logic [ADDR_W-1:0] sp_value
);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(STACK_BYTES - 1);
  localparam logic [ADDR_W-1:0] VEC_LO_A = VEC_ADDR + 1'b1;

  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] sp_q, sp_d;
  logic [15:0]       pc_s;
  logic [7:0]        x_s, a_s, ccr_s;
  logic [7:0]        vhi_q;
  logic              vhi_en;

  assign start = (state_q == SQ_IDLE) && insn_boundary && request && !ccr_in[MASK_BIT];

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    sp_d    = sp_q;
    case (state_q)
      SQ_IDLE: if (start) begin
        state_d = SQ_PUSH;
        idx_d   = '0;
        sp_d    = sp_in;
      end
      SQ_PUSH: begin
        sp_d = sp_q - 1'b1;
        if (idx_q == LAST_IDX) state_d = SQ_VEC_HI;
        else                   idx_d   = idx_q + 1'b1;
      end
      SQ_VEC_HI: state_d = SQ_VEC_LO;
      SQ_VEC_LO: state_d = SQ_LOAD;
      SQ_LOAD:   state_d = SQ_IDLE;
      default:   state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      sp_q    <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sp_q    <= sp_d;
    end
  end

  // register snapshot taken at the accepting boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_s  <= '0;
      x_s   <= '0;
      a_s   <= '0;
      ccr_s <= '0;
    end else if (start) begin
      pc_s  <= pc_in;
      x_s   <= x_in;
      a_s   <= a_in;
      ccr_s <= ccr_in;
    end
  end

  assign vhi_en = (state_q == SQ_VEC_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vhi_q <= '0;
    else if (vhi_en) vhi_q <= mem_rdata;
  end

  always_comb begin
    case (idx_q)
      3'd0:    mem_wdata = pc_s[7:0];
      3'd1:    mem_wdata = pc_s[15:8];
      3'd2:    mem_wdata = x_s;
      3'd3:    mem_wdata = a_s;
      default: mem_wdata = ccr_s;
    endcase
  end

  always_comb begin
    case (state_q)
      SQ_VEC_HI: mem_addr = VEC_ADDR;
      SQ_VEC_LO: mem_addr = VEC_LO_A;
      default:   mem_addr = sp_q;
    endcase
  end

  assign busy      = (state_q != SQ_IDLE);
  assign mem_we    = (state_q == SQ_PUSH);
  assign mem_re    = (state_q == SQ_VEC_HI) || (state_q == SQ_VEC_LO);
  assign imask_set = (state_q == SQ_VEC_HI);
  assign pc_load   = (state_q == SQ_LOAD);
  assign sp_load   = (state_q == SQ_LOAD);
  assign pc_value  = {vhi_q, mem_rdata};
  assign sp_value  = sp_q;

  AST_MASKED_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ccr_in[MASK_BIT]) |=> !busy); // R1
  AST_STACK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == ADDR_W'($past(mem_addr) - 1'b1))); // R2
  AST_MASK_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we) |-> imask_set); // R3
  AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> ($past(mem_re) && !mem_re)); // R4
  AST_WRITE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re || pc_load) |-> busy); // R5
endmodule

// File: rtl/irq_spacing_mon.sv
module irq_spacing_mon #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall,
  input  logic             start,
  input  logic             rti_strobe,
  output logic             violation,
  output logic [CNT_W-1:0] gap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             svc_q, svc_d;
  logic             viol_q, viol_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] gap_q, gap_d;

  always_comb begin
    svc_d = svc_q;
    if (rti_strobe) svc_d = 1'b0;
    else if (start) svc_d = 1'b1;
    viol_d = viol_q | (fall & svc_q & ~rti_strobe);
  end

  always_comb begin
    gap_d = gap_q;
    cnt_d = cnt_q;
    if (fall) begin
      gap_d = cnt_q;
      cnt_d = CNT_W'(1);
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_q  <= 1'b0;
      viol_q <= 1'b0;
      cnt_q  <= '0;
      gap_q  <= '0;
    end else begin
      svc_q  <= svc_d;
      viol_q <= viol_d;
      cnt_q  <= cnt_d;
      gap_q  <= gap_d;
    end
  end

  assign violation = viol_q;
  assign gap       = gap_q;

  AST_VIOLATION_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation); // R10
  AST_VIOLATION_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(violation) |-> $past(svc_q)); // R10
  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(gap)); // R11
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_seq_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 13,
  parameter int unsigned       MASK_BIT    = 3,
  parameter logic [ADDR_W-1:0] VEC_ADDR    = 13'h1FFA,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_n,
  input  logic              insn_boundary,
  input  logic              rti_strobe,
  input  logic [15:0]       pc_in,
  input  logic [7:0]        x_in,
  input  logic [7:0]        a_in,
  input  logic [7:0]        ccr_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [7:0]        mem_rdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              imask_set,
  output logic              pc_load,
  output logic [15:0]       pc_value,
  output logic              sp_load,
  output logic [ADDR_W-1:0] sp_value,
  output logic              pulse_violation,
  output logic [CNT_W-1:0]  pulse_gap
);
  logic [1:0] rst_sync_q;
  logic       srst_n;
  logic       line_low, fall, pending, request, start;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  irq_req_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
    .clk      (clk),
    .rst_n    (srst_n),
    .irq_n    (irq_n),
    .clear    (start),
    .line_low (line_low),
    .fall     (fall),
    .pending  (pending)
  );

  assign request = pending | line_low;

  irq_entry_seq #(
    .ADDR_W   (ADDR_W),
    .MASK_BIT (MASK_BIT),
    .VEC_ADDR (VEC_ADDR)
  ) u_seq (
    .clk           (clk),
    .rst_n         (srst_n),
    .insn_boundary (insn_boundary),
    .request       (request),
    .pc_in         (pc_in),
    .x_in          (x_in),
    .a_in          (a_in),
    .ccr_in        (ccr_in),
    .sp_in         (sp_in),
    .mem_rdata     (mem_rdata),
    .start         (start),
    .busy          (busy),
    .mem_we        (mem_we),
    .mem_re        (mem_re),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .imask_set     (imask_set),
    .pc_load       (pc_load),
    .pc_value      (pc_value),
    .sp_load       (sp_load),
    .sp_value      (sp_value)
  );

  irq_spacing_mon #(.CNT_W(CNT_W)) u_mon (
    .clk        (clk),
    .rst_n      (srst_n),
    .fall       (fall),
    .start      (start),
    .rti_strobe (rti_strobe),
    .violation  (pulse_violation),
    .gap        (pulse_gap)
  );

  AST_ONE_MEM_OP: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({mem_we, mem_re, pc_load})); // R4
  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(busy) |-> $past(request && insn_boundary)); // R1
endmodule

// File: tb/sim_irq_sequencer.sv
module sim_irq_sequencer;
  localparam int unsigned AW = 13;
  localparam int unsigned CW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          irq_n;
  logic          insn_boundary;
  logic          rti_strobe;
  logic [15:0]   pc_in;
  logic [7:0]    x_in, a_in, ccr_in;
  logic [AW-1:0] sp_in;
  logic [7:0]    mem_rdata;
  logic          mem_we, mem_re, busy, imask_set, pc_load, sp_load, pulse_violation;
  logic [AW-1:0] mem_addr, sp_value;
  logic [7:0]    mem_wdata;
  logic [15:0]   pc_value;
  logic [CW-1:0] pulse_gap;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_sequencer #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .insn_boundary(insn_boundary),
    .rti_strobe(rti_strobe), .pc_in(pc_in), .x_in(x_in), .a_in(a_in),
    .ccr_in(ccr_in), .sp_in(sp_in), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .imask_set(imask_set), .pc_load(pc_load), .pc_value(pc_value),
    .sp_load(sp_load), .sp_value(sp_value), .pulse_violation(pulse_violation),
    .pulse_gap(pulse_gap)
  );

  // vector memory model, one cycle read latency
  always @(posedge clk) begin
    if (mem_re)
      mem_rdata <= (mem_addr == 13'h1FFA) ? 8'h1C :
                   (mem_addr == 13'h1FFB) ? 8'h40 : 8'hEE;
  end

  // core model: mask bit 3 set on request
  always @(posedge clk) begin
    if (imask_set) ccr_in <= ccr_in | 8'h08;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; irq_n = 1'b1; rti_strobe = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
  endtask

  task automatic pulse();
    irq_n = 1'b0;
    tick(2);
    irq_n = 1'b1;
  endtask

  task automatic rti();
    rti_strobe = 1'b1;
    ccr_in = ccr_in & 8'hF7;
    tick(1);
    rti_strobe = 1'b0;
  endtask

  task automatic wait_busy(input int maxc, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < maxc && !seen; i++) begin
      tick(1);
      if (busy) seen = 1'b1;
    end
  endtask

  task automatic quiet(input int n, input string tag);
    bit any = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (busy) any = 1'b1;
    end
    chk(!any, tag, any, 0);
  endtask

  // called at the first push cycle; runs to one cycle after the load
  task automatic finish_entry();
    tick(8);
  endtask

  task automatic t_reset();
    reset_dut();
    chk(!busy && !mem_we && !mem_re, "R12 idle strobes", {busy, mem_we, mem_re}, 0);
    chk(!pc_load && !sp_load && !imask_set, "R12 load strobes", {pc_load, sp_load, imask_set}, 0);
    chk(!pulse_violation && pulse_gap == 0, "R12 monitor", {pulse_violation, pulse_gap}, 0);
  endtask

  task automatic t_full_entry();
    bit seen;
    logic [7:0] exp_b [5];
    exp_b[0] = pc_in[7:0]; exp_b[1] = pc_in[15:8]; exp_b[2] = x_in;
    exp_b[3] = a_in;       exp_b[4] = 8'h05;
    ccr_in = 8'h05;
    pulse();
    wait_busy(10, seen);
    chk(seen, "R1 entry on pulse", seen, 1);
    for (int i = 0; i < 5; i++) begin
      chk(mem_we && mem_addr == sp_in - AW'(i), "R2 push address", mem_addr, sp_in - AW'(i));
      chk(mem_wdata == exp_b[i], "R2 push data", mem_wdata, exp_b[i]);
      chk(busy && !imask_set, "R5 busy during push", {busy, imask_set}, 2);
      tick(1);
    end
    chk(imask_set && !mem_we, "R3 mask set after push", {imask_set, mem_we}, 2);
    chk(mem_re && mem_addr == 13'h1FFA, "R4 vector high read", mem_addr, 13'h1FFA);
    tick(1);
    chk(!imask_set && mem_re && mem_addr == 13'h1FFB, "R4 vector low read", mem_addr, 13'h1FFB);
    tick(1);
    chk(pc_load && pc_value == 16'h1C40, "R4 pc value", pc_value, 16'h1C40);
    chk(sp_load && sp_value == sp_in - 5, "R4 sp value", sp_value, sp_in - 5);
    chk(busy, "R5 busy at load", busy, 1);
    tick(1);
    chk(!busy && !pc_load, "R5 busy released", busy, 0);
    chk(ccr_in[3], "R3 core mask set", ccr_in, 8'h0D);
    tick(5);
    rti();
    quiet(20, "R7 single pulse serviced once");
  endtask

  task automatic t_boundary();
    bit seen;
    insn_boundary = 1'b0;
    irq_n = 1'b0;
    quiet(10, "R1 no entry without boundary");
    insn_boundary = 1'b1;
    wait_busy(4, seen);
    chk(seen, "R1 entry at boundary", seen, 1);
    finish_entry();
    irq_n = 1'b1;
    tick(3);
    rti();
    quiet(10, "R1 line released");
  endtask

  task automatic t_masked();
    bit seen;
    ccr_in = 8'h08;
    pulse();
    quiet(20, "R6 masked pulse held off");
    ccr_in = 8'h00;
    wait_busy(4, seen);
    chk(seen, "R6 pending taken on unmask", seen, 1);
    finish_entry();
    tick(3);
    rti();
    quiet(20, "R7 no repeat after pending serviced");
  endtask

  task automatic t_held_low();
    bit seen;
    ccr_in = 8'h00;
    irq_n = 1'b0;
    wait_busy(10, seen);
    chk(seen, "R8 first entry", seen, 1);
    finish_entry();
    tick(5);
    rti();
    wait_busy(4, seen);
    chk(seen, "R8 re-entry on held line", seen, 1);
    finish_entry();
    irq_n = 1'b1;
    tick(3);
    rti();
    quiet(10, "R8 stops after release");
    chk(!pulse_violation, "R10 held line no violation", pulse_violation, 0);
  endtask

  task automatic t_reset_clears();
    ccr_in = 8'h08;
    pulse();
    tick(5);
    reset_dut();
    ccr_in = 8'h00;
    quiet(20, "R9 reset drops pending");
  endtask

  task automatic t_violation();
    bit seen;
    ccr_in = 8'h00;
    pulse();
    wait_busy(10, seen);
    tick(12);
    pulse();
    tick(5);
    chk(pulse_violation, "R10 pulse during service", pulse_violation, 1);
    tick(10);
    chk(pulse_violation, "R10 flag sticky", pulse_violation, 1);
    reset_dut();
    ccr_in = 8'h00;
    pulse();
    wait_busy(10, seen);
    tick(12);
    rti();
    tick(3);
    pulse();
    wait_busy(10, seen);
    chk(seen, "R10 later pulse taken", seen, 1);
    tick(3);
    chk(!pulse_violation, "R10 pulse after return", pulse_violation, 0);
    finish_entry();
    rti();
  endtask

  task automatic t_gap();
    reset_dut();
    ccr_in = 8'h08;
    pulse();
    tick(8);
    pulse();
    tick(5);
    chk(pulse_gap == 10, "R11 ten cycle spacing", pulse_gap, 10);
    tick(100);
    pulse();
    tick(5);
    chk(pulse_gap == 63, "R11 saturation", pulse_gap, 63);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    insn_boundary = 1'b1;
    pc_in = 16'hA5C3; x_in = 8'h12; a_in = 8'h34; ccr_in = 8'h05;
    sp_in = 13'h00FF;
    irq_n = 1'b1; rti_strobe = 1'b0; rst_n = 1'b0;
    t_reset();
    t_full_entry();
    t_boundary();
    t_masked();
    t_held_low();
    t_reset_clears();
    t_violation();
    t_gap();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule